// File: doc/BRIEF.md
# Write Aggregation Buffer with Read Bypass

This block sits between a core-side store buffer and a data cache and keeps writes away from the cache for as long as it can. Read requests pass through to the cache port on the next cycle. Write requests are parked in an internal queue of `DEPTH` slots. Once every slot is taken, a full flag rises. The whole group then goes to the cache as one ordered burst, but only during cycles in which an external release enable is high. Because the cache sees long runs of reads broken by rare write bursts, a memory supply can stay at a low level for reads and rise only for the burst.

A read that matches a parked write is answered straight from the queue on a response port, and the cache never sees it. A read that arrives during a burst takes the cache port for that cycle, and the burst picks up again on the next cycle. A write to an address already parked replaces that entry's data and does not take a new slot. While the flag is up, which covers both the full state and the burst, new writes are refused through a ready signal. Reads are always taken. `rst_n` is asynchronous and active low, and is expected to be deasserted synchronously to `clk` by the reset logic upstream.

Top module: `wagg_buf`

## Requirements
- R1: During and right after reset, `full`, `cache_valid` and `rsp_valid` are 0 and `req_ready` is 1.
- R2: A read (`req_we`=0) whose address matches no parked write shows up on the cache port in the next cycle, with `cache_valid`=1, `cache_we`=0 and `cache_addr` equal to the request address.
- R3: An accepted write (`req_we`=1) to a new address is stored in the queue and causes no cache activity and no response in the next cycle.
- R4: `full` rises in the cycle after the write that fills the last of the `DEPTH` slots is accepted, and not earlier.
- R5: While `full` is 1, `req_ready` is 0 and an offered write is dropped with no effect. A later read of its address after the burst goes to the cache.
- R6: Parked writes reach the cache only in cycles that follow a clock edge at which `drain_en` was 1. While `full` is 1 and `drain_en` is 0, `cache_valid` stays 0.
- R7: A burst starts only once `full` is 1 and sends every parked entry as `cache_valid`=1, `cache_we`=1, one per cycle, in the order the slots were first filled.
- R8: A read offered during a burst takes the cache port in the next cycle. No burst write goes out in that cycle, and the burst resumes with the next unsent entry.
- R9: A read matching a parked write gives `rsp_valid`=1 with that entry's data in the next cycle and leaves `cache_valid` at 0. Among several matches the youngest is used.
- R10: A write to an address already parked overwrites that entry's data in place. A later bypass read returns the new data, and no extra slot is used.
- R11: `full` falls in the same cycle that the last burst write appears, after which writes are accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Writes are taken when 1; reads are always taken |
| drain_en | input | 1 | Release enable for the write burst |
| full | output | 1 | Queue is full or a burst is in progress |
| cache_valid | output | 1 | Cache request valid |
| cache_we | output | 1 | Cache request is a write |
| cache_addr | output | 16 | Cache request address |
| cache_wdata | output | 32 | Cache write data |
| rsp_valid | output | 1 | Bypass read response valid |
| rsp_data | output | 32 | Bypass read data |

## Verification
The bench builds the block with `DEPTH`=32, the smallest supported depth. At this size a full fill and a complete burst take a few dozen cycles. That makes it practical to check the last-slot boundary for the full flag, with an overwrite placed before it so that a leaked slot would raise the flag one write early. It also makes it practical to walk every entry of a burst in order while a cache read, a bypass read, a release pause and a refused write are placed at known points in the middle of it.

// File: rtl/wagg_pkg.sv
package wagg_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wentry_t;
endpackage

// File: rtl/wagg_store.sv
module wagg_store
  import wagg_pkg::*;
#(
  parameter  int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  wentry_t           wr_ent,
  input  logic [DEPTH-1:0]  live,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx,
  output logic [DATA_W-1:0] hit_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output wentry_t           rd_ent
);
  wentry_t          slot [DEPTH];
  logic [DEPTH-1:0] match;

  always_ff @(posedge clk) begin
    if (wr_en) slot[wr_idx] <= wr_ent;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = live[g] && (slot[g].addr == look_addr);
  end

  // Highest matching index is the youngest entry.
  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit      = |match;
  assign hit_data = slot[hit_idx].data;
  assign rd_ent   = slot[rd_idx];
endmodule

// File: rtl/wagg_ctrl.sv
module wagg_ctrl #(
  parameter  int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [CNT_W-1:0] count,
  output logic [IDX_W-1:0] head,
  output logic             full,
  output logic [DEPTH-1:0] live
);
  logic [CNT_W-1:0] count_n;
  logic [IDX_W-1:0] head_n;
  logic             full_n;
  logic             ce;

  assign ce = push | pop;

  always_comb begin
    count_n = count;
    head_n  = head;
    full_n  = full;
    if (push) begin
      count_n = count + 1'b1;
      if (count_n == CNT_W'(DEPTH)) full_n = 1'b1;
    end else if (pop) begin
      if (head == IDX_W'(DEPTH - 1)) begin
        head_n  = '0;
        count_n = '0;
        full_n  = 1'b0;
      end else begin
        head_n = head + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      head  <= '0;
      full  <= 1'b0;
    end else if (ce) begin
      count <= count_n;
      head  <= head_n;
      full  <= full_n;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_live
    assign live[g] = (IDX_W'(g) >= head) && (CNT_W'(g) < count);
  end
endmodule

// File: rtl/wagg_buf.sv
module wagg_buf
  import wagg_pkg::*;
#(
  parameter  int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  input  logic              drain_en,
  output logic              full,
  output logic              cache_valid,
  output logic              cache_we,
  output logic [ADDR_W-1:0] cache_addr,
  output logic [DATA_W-1:0] cache_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  logic [CNT_W-1:0]  count;
  logic [IDX_W-1:0]  head;
  logic [DEPTH-1:0]  live;
  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  logic [DATA_W-1:0] hit_data;
  wentry_t           head_ent;

  logic rd_req, wr_req, push, pop, st_wr;
  logic [IDX_W-1:0] st_idx;

  logic              cv_n, cwe_n, rv_n, c_ce, r_ce;
  logic [ADDR_W-1:0] ca_n;
  logic [DATA_W-1:0] cd_n;

  assign req_ready = ~full;
  assign rd_req    = req_valid & ~req_we;
  assign wr_req    = req_valid & req_we & ~full;
  assign st_wr     = wr_req;
  assign push      = wr_req & ~hit;
  assign st_idx    = hit ? hit_idx : count[IDX_W-1:0];
  assign pop       = full & drain_en & ~rd_req;

  wagg_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (pop),
    .count (count),
    .head  (head),
    .full  (full),
    .live  (live)
  );

  wagg_store #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .wr_en     (st_wr),
    .wr_idx    (st_idx),
    .wr_ent    ('{addr: req_addr, data: req_wdata}),
    .live      (live),
    .look_addr (req_addr),
    .hit       (hit),
    .hit_idx   (hit_idx),
    .hit_data  (hit_data),
    .rd_idx    (head),
    .rd_ent    (head_ent)
  );

  // Next state of the cache and response ports.
  always_comb begin
    cv_n  = (rd_req & ~hit) | pop;
    cwe_n = pop;
    ca_n  = pop ? head_ent.addr : req_addr;
    cd_n  = pop ? head_ent.data : '0;
    rv_n  = rd_req & hit;
    c_ce  = cv_n;
    r_ce  = rv_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cache_valid <= 1'b0;
      cache_we    <= 1'b0;
      rsp_valid   <= 1'b0;
    end else begin
      cache_valid <= cv_n;
      cache_we    <= cwe_n;
      rsp_valid   <= rv_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cache_addr  <= '0;
      cache_wdata <= '0;
    end else if (c_ce) begin
      cache_addr  <= ca_n;
      cache_wdata <= cd_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_data <= '0;
    end else if (r_ce) begin
      rsp_data <= hit_data;
    end
  end
endmodule

// File: rtl/wagg_buf_chk.sv
module wagg_buf_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_we,
  input logic drain_en,
  input logic full,
  input logic cache_valid,
  input logic cache_we,
  input logic rsp_valid
);
  AST_DRAIN_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_valid && cache_we) |-> $past(drain_en)); // R6

  AST_DRAIN_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_valid && cache_we) |-> $past(full)); // R7

  AST_READ_PREEMPTS_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we) |=> !(cache_valid && cache_we)); // R8

  AST_BYPASS_NO_CACHE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cache_valid); // R9

  AST_FULL_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(req_valid && req_we)); // R4

  AST_FULL_CLEARS_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full) |-> (cache_valid && cache_we)); // R11
endmodule

bind wagg_buf wagg_buf_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_we      (req_we),
  .drain_en    (drain_en),
  .full        (full),
  .cache_valid (cache_valid),
  .cache_we    (cache_we),
  .rsp_valid   (rsp_valid)
);

// File: tb/tb_wagg_buf.sv
module tb_wagg_buf;
  localparam int DEPTH = 32;
  localparam int NV    = 8;

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_we, drain_en;
  logic [15:0] req_addr;
  logic [31:0] req_wdata;
  logic        req_ready, full, cache_valid, cache_we, rsp_valid;
  logic [15:0] cache_addr;
  logic [31:0] cache_wdata, rsp_data;

  int checks;
  int failures;
  bit done;

  // {we, addr, data, kind, expect}; kind 0 = idle, 1 = cache read, 2 = bypass
  localparam logic [82:0] TBL [NV] = '{
    {1'b1, 16'h0010, 32'h0000_00A0, 2'd0, 32'h0},
    {1'b1, 16'h0020, 32'h0000_00B0, 2'd0, 32'h0},
    {1'b0, 16'h0010, 32'h0,         2'd2, 32'h0000_00A0},
    {1'b0, 16'h0300, 32'h0,         2'd1, 32'h0000_0300},
    {1'b1, 16'h0010, 32'h0000_00C0, 2'd0, 32'h0},
    {1'b0, 16'h0010, 32'h0,         2'd2, 32'h0000_00C0},
    {1'b0, 16'h0020, 32'h0,         2'd2, 32'h0000_00B0},
    {1'b0, 16'h0040, 32'h0,         2'd1, 32'h0000_0040}
  };

  wagg_buf #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .drain_en(drain_en),
    .full(full), .cache_valid(cache_valid), .cache_we(cache_we),
    .cache_addr(cache_addr), .cache_wdata(cache_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [15:0] ea(int i);
    if (i == 0) return 16'h0010;
    if (i == 1) return 16'h0020;
    return 16'(32'h1000 + i);
  endfunction

  function automatic logic [31:0] ed(int i);
    if (i == 0) return 32'h0000_00C0;
    if (i == 1) return 32'h0000_00B0;
    return 32'h5A00_0000 + 32'(i);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_in();
    req_valid = 1'b0;
    req_we    = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
    end
  end

  initial begin
    int exp_idx;
    checks = 0;
    failures = 0;
    done = 1'b0;
    rst_n = 1'b0;
    drain_en = 1'b0;
    idle_in();
    repeat (3) @(posedge clk);
    #1;
    chk(!full && req_ready && !cache_valid && !rsp_valid, "R1", "reset state",
        {28'h0, full, req_ready, cache_valid, rsp_valid}, 32'h4);
    rst_n = 1'b1;
    step();
    chk(!full && req_ready && !cache_valid && !rsp_valid, "R1", "after reset",
        {28'h0, full, req_ready, cache_valid, rsp_valid}, 32'h4);

    // Table walk: writes, cache reads, bypass reads, overwrite
    for (int v = 0; v < NV; v++) begin
      req_valid = 1'b1;
      req_we    = TBL[v][82];
      req_addr  = TBL[v][81:66];
      req_wdata = TBL[v][65:34];
      step();
      idle_in();
      case (TBL[v][33:32])
        2'd0: chk(!cache_valid && !rsp_valid, "R3", "write quiet",
                  {30'h0, cache_valid, rsp_valid}, 32'h0);
        2'd1: chk(cache_valid && !cache_we && cache_addr == TBL[v][15:0], "R2",
                  "cache read addr", {15'h0, cache_valid, cache_addr}, {16'h1, TBL[v][15:0]});
        default: chk(rsp_valid && !cache_valid && rsp_data == TBL[v][31:0], "R9 R10",
                  "bypass data", rsp_data, TBL[v][31:0]);
      endcase
    end

    // Fill remaining 30 slots; overwrite above must not have used a slot
    for (int j = 2; j < DEPTH; j++) begin
      if (j == DEPTH - 1) chk(!full, "R10", "full before last slot", {31'h0, full}, 32'h0);
      req_valid = 1'b1;
      req_we    = 1'b1;
      req_addr  = ea(j);
      req_wdata = ed(j);
      step();
    end
    idle_in();
    chk(full, "R4", "full after last slot", {31'h0, full}, 32'h1);

    // Full, release low: write refused, nothing drains
    req_valid = 1'b1;
    req_we    = 1'b1;
    req_addr  = 16'h7777;
    req_wdata = 32'hDEAD_0000;
    #1;
    chk(!req_ready, "R5", "ready while full", {31'h0, req_ready}, 32'h0);
    for (int k = 0; k < 3; k++) begin
      step();
      chk(!cache_valid && full, "R6", "held without release",
          {30'h0, cache_valid, full}, 32'h1);
    end
    idle_in();

    // Burst with a cache read, a bypass read, a release gap and a refused write
    exp_idx = 0;
    for (int cyc = 0; cyc < 200 && exp_idx < DEPTH; cyc++) begin
      idle_in();
      drain_en = 1'b1;
      if (cyc == 4) begin
        req_valid = 1'b1; req_addr = 16'h5000;
      end else if (cyc == 8) begin
        req_valid = 1'b1; req_addr = ea(20);
      end else if (cyc == 11 || cyc == 12) begin
        drain_en = 1'b0;
      end else if (cyc == 14) begin
        req_valid = 1'b1; req_we = 1'b1; req_addr = 16'h7777; req_wdata = 32'hDEAD_0001;
      end
      step();
      if (cyc == 4) begin
        chk(cache_valid && !cache_we && cache_addr == 16'h5000, "R8", "read preempts burst",
            {15'h0, cache_we, cache_addr}, 32'h5000);
      end else if (cyc == 8) begin
        chk(rsp_valid && !cache_valid && rsp_data == ed(20), "R9", "bypass during burst",
            rsp_data, ed(20));
      end else if (cyc == 11 || cyc == 12) begin
        chk(!cache_valid, "R6", "release low pauses", {31'h0, cache_valid}, 32'h0);
      end else begin
        chk(cache_valid && cache_we && cache_addr == ea(exp_idx) && cache_wdata == ed(exp_idx),
            "R7", "burst order", cache_wdata, ed(exp_idx));
        if (exp_idx == DEPTH - 1)
          chk(!full, "R11", "full clears on last", {31'h0, full}, 32'h0);
        exp_idx++;
      end
    end
    idle_in();
    drain_en = 1'b0;
    chk(exp_idx == DEPTH, "R7", "all entries drained", 32'(exp_idx), 32'(DEPTH));

    // Refused writes left no trace
    req_valid = 1'b1; req_addr = 16'h7777;
    step();
    chk(cache_valid && !cache_we && !rsp_valid && cache_addr == 16'h7777, "R5",
        "refused write absent", {15'h0, rsp_valid, cache_addr}, 32'h7777);

    // Accepting again after the burst
    req_we = 1'b1; req_wdata = 32'h0000_0077;
    #1;
    chk(req_ready, "R11", "ready after burst", {31'h0, req_ready}, 32'h1);
    step();
    req_we = 1'b0;
    step();
    idle_in();
    chk(rsp_valid && rsp_data == 32'h77, "R11", "new write buffered", rsp_data, 32'h77);

    finish_run();
  end
endmodule